// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block supplies the digital timing for a successive-approximation analog-to-digital converter. It builds a conversion-clock rhythm from the system clock with one of seven divide ratios, some of them not powers of two. It can instead follow a slow secondary clock, undivided. The result is a one-cycle enable per conversion-clock period, not a gated clock. When a start request arrives, the block latches its control fields. It then holds the sampling strobe high for a programmable number of conversion-clock periods and emits eighteen conversion-step strobes. After a short tail counted in system clocks it raises a single-cycle completion pulse.

The analog side takes the latched channel code, the sampling strobe and the step strobes from this block. The comparator, the DAC and any register interface sit outside it, and the control fields arrive as plain input ports. A start with an unusable sample-hold code is refused and flagged. A separate combinational flag reports whether the selected clock source and divider give a conversion-clock period outside the permitted window of 750 ns to 100 µs. The window is computed from the clock periods given as parameters.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle: `busy`, `sample_en`, `step`, `done`, `err` and `ch_sel` are all 0 after that edge.
- R2: For `clk_sel` 0..6 the conversion-clock ratio is /2, /3, /4, /6, /8, /12, /16. `done` is high exactly (18 + S) × D + 3 system clocks after the edge that accepts the start, where D is the ratio and S the sample-hold count.
- R3: `hold_sel` 0, 1, 2 gives S = 2, 6, 18. `sample_en` is high for exactly S × D cycles, starting in the cycle after the accepting edge.
- R4: After sampling, `step` gives exactly 18 one-cycle pulses, spaced D cycles apart. The first comes (S + 1) × D cycles after acceptance, and `sample_en` is never high together with `step`.
- R5: `done` lasts one cycle and comes exactly 3 cycles after the last `step` pulse. `busy` is low in the `done` cycle and high in every cycle between acceptance and `done`.
- R6: `ch_sel` takes the `chan` input at acceptance and holds it until `done`, whatever `chan` does in between.
- R7: A `start` while `busy` is high is ignored: the running conversion keeps its timing and produces one `done`, and no conversion follows.
- R8: A `start` with `hold_sel` = 3 raises `err` for one cycle, in the cycle after the request. No conversion starts and `busy` stays low.
- R9: `clk_sel` = 7 times the conversion from the rising edges of `slow_clk` (after synchronisation). The step pulses are spaced one slow-clock period apart, there are 18 of them, and `done` comes 3 cycles after the last one.
- R10: `clk_sel_bad` is high exactly when the selected source gives a period outside the window [`TCONV_MIN_PS`, `TCONV_MAX_PS`]. That period is D × `SYS_PERIOD_PS` for codes 0..6, or `SLOW_PERIOD_PS` for code 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_clk | input | 1 | Secondary slow clock, sampled as data |
| start | input | 1 | Conversion request |
| clk_sel | input | 3 | Conversion-clock source and divider code |
| hold_sel | input | 2 | Sample-hold length code |
| chan | input | 3 | Analog channel to convert |
| clk_sel_bad | output | 1 | Selected conversion-clock period outside the permitted window |
| busy | output | 1 | Conversion in progress |
| ch_sel | output | 3 | Latched channel code |
| sample_en | output | 1 | Sample-and-hold phase active |
| step | output | 1 | One pulse per conversion-clock cycle of the conversion phase |
| done | output | 1 | Single-cycle completion pulse |
| err | output | 1 | Start refused because of a bad sample-hold code |

## Verification
The main instance is built with a 200 ns system-clock period and a 30.5 µs slow-clock period. With those values codes /2 and /3 land below the window and every other code lands inside it. A second instance uses a 150 µs slow period, so the slow source itself becomes out of range and the code-7 path of the range flag can be checked. In the bench the slow clock toggles every five system clocks. This lets the slow-source conversion finish in a few hundred cycles and gives it an exact ten-cycle step spacing that can be checked.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CLK_CODE_W = 3;
    localparam int HOLD_CODE_W = 2;
    localparam int CH_W = 3;
    localparam int MAX_RATIO = 16;
    localparam int RATIO_W = $clog2(MAX_RATIO) + 1;
    localparam int PH_W = 5;

    localparam logic [CLK_CODE_W-1:0] CLK_SLOW = 3'b111;
    localparam logic [HOLD_CODE_W-1:0] HOLD_BAD = 2'b11;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_CONV,
        PH_TAIL,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CLK_CODE_W-1:0]  ck;
        logic [HOLD_CODE_W-1:0] sh;
        logic [CH_W-1:0]        ch;
    } conv_cfg_t;

    // Divide ratio for a clock-select code; the slow source is undivided.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CLK_CODE_W-1:0] code);
        case (code)
            3'd0:    return RATIO_W'(2);
            3'd1:    return RATIO_W'(3);
            3'd2:    return RATIO_W'(4);
            3'd3:    return RATIO_W'(6);
            3'd4:    return RATIO_W'(8);
            3'd5:    return RATIO_W'(12);
            3'd6:    return RATIO_W'(16);
            default: return RATIO_W'(1);
        endcase
    endfunction

    // Sample-hold length in conversion-clock periods.
    function automatic logic [PH_W-1:0] hold_len(input logic [HOLD_CODE_W-1:0] code);
        case (code)
            2'd0:    return PH_W'(2);
            2'd1:    return PH_W'(6);
            2'd2:    return PH_W'(18);
            default: return PH_W'(1);
        endcase
    endfunction

    // Conversion-clock period in ps for one code.
    function automatic longint period_ps(input int code, input longint sys_ps,
                                         input longint slow_ps);
        if (code == 7) return slow_ps;
        return longint'(ratio_of(CLK_CODE_W'(code))) * sys_ps;
    endfunction

    function automatic bit period_in_window(input int code, input longint sys_ps,
                                            input longint slow_ps, input longint lo_ps,
                                            input longint hi_ps);
        longint p;
        p = period_ps(code, sys_ps, slow_ps);
        return (p >= lo_ps) && (p <= hi_ps);
    endfunction

endpackage

// File: rtl/adc_range_check.sv
module adc_range_check
    import adc_seq_pkg::*;
#(
    parameter longint SYS_PERIOD_PS  = 200000,
    parameter longint SLOW_PERIOD_PS = 30517578,
    parameter longint TCONV_MIN_PS   = 750000,
    parameter longint TCONV_MAX_PS   = 100000000
) (
    input  logic [CLK_CODE_W-1:0] code,
    output logic                  bad
);
    localparam int N_CODES = 1 << CLK_CODE_W;

    logic [N_CODES-1:0] ok_vec;

    // One constant legality bit per code, folded from the clock parameters.
    for (genvar i = 0; i < N_CODES; i++) begin : g_code
        localparam bit CODE_OK = period_in_window(i, SYS_PERIOD_PS, SLOW_PERIOD_PS,
                                                  TCONV_MIN_PS, TCONV_MAX_PS);
        assign ok_vec[i] = CODE_OK;
    end

    assign bad = ~ok_vec[code];

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               slow_clk,
    input  logic               restart,
    input  logic               run,
    input  logic               use_slow,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int CNT_W = RATIO_W - 1;

    logic [CNT_W-1:0] div_cnt;
    logic [2:0]       slow_sync;
    logic             div_wrap;
    logic             slow_rise;

    // Modulo counter: wraps at ratio-1, so odd ratios need no special case.
    assign div_wrap = ({1'b0, div_cnt} == (ratio - RATIO_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_cnt <= '0;
        end else if (run) begin
            div_cnt <= div_wrap ? '0 : div_cnt + CNT_W'(1);
        end
    end

    // Two-stage synchroniser plus an edge register for the slow source.
    always_ff @(posedge clk) begin
        if (rst) begin
            slow_sync <= '0;
        end else begin
            slow_sync <= {slow_sync[1:0], slow_clk};
        end
    end

    assign slow_rise = slow_sync[1] & ~slow_sync[2];

    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (use_slow) begin
            tick = slow_rise;
        end else begin
            tick = div_wrap;
        end
    end

endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
    import adc_seq_pkg::*;
#(
    parameter int STEP_CYCLES = 18,
    parameter int TAIL_CYCLES = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  conv_cfg_t cfg_in,
    input  logic      tick,
    output conv_cfg_t cfg_q,
    output logic      accept,
    output logic      run,
    output logic      busy,
    output logic      sample_en,
    output logic      step,
    output logic      done,
    output logic      err
);
    localparam int TL_W = $clog2(TAIL_CYCLES + 1);
    localparam logic [PH_W-1:0] STEP_LAST = PH_W'(STEP_CYCLES - 1);
    // The done cycle itself is the last tail cycle, so the tail state lasts one less.
    localparam logic [TL_W-1:0] TAIL_LAST = TL_W'(TAIL_CYCLES - 2);

    phase_e          phase;
    logic [PH_W-1:0] ph_cnt;
    logic [TL_W-1:0] tl_cnt;
    logic [PH_W-1:0] hold_last;
    logic            idle_like;
    logic            err_q;

    assign idle_like = (phase == PH_IDLE) || (phase == PH_DONE);
    assign accept    = start && idle_like && (cfg_in.sh != HOLD_BAD);
    assign hold_last = hold_len(cfg_q.sh) - PH_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cfg_q  <= '0;
            ph_cnt <= '0;
            tl_cnt <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (phase)
                PH_IDLE, PH_DONE: begin
                    phase <= PH_IDLE;
                    if (start) begin
                        if (cfg_in.sh == HOLD_BAD) begin
                            err_q <= 1'b1;
                        end else begin
                            cfg_q  <= cfg_in;
                            phase  <= PH_SAMPLE;
                            ph_cnt <= '0;
                        end
                    end
                end
                PH_SAMPLE: begin
                    if (tick) begin
                        if (ph_cnt == hold_last) begin
                            phase  <= PH_CONV;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + PH_W'(1);
                        end
                    end
                end
                PH_CONV: begin
                    if (tick) begin
                        if (ph_cnt == STEP_LAST) begin
                            phase  <= PH_TAIL;
                            tl_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + PH_W'(1);
                        end
                    end
                end
                PH_TAIL: begin
                    if (tl_cnt == TAIL_LAST) begin
                        phase <= PH_DONE;
                    end else begin
                        tl_cnt <= tl_cnt + TL_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign run       = (phase == PH_SAMPLE) || (phase == PH_CONV);
    assign busy      = run || (phase == PH_TAIL);
    assign sample_en = (phase == PH_SAMPLE);
    assign step      = (phase == PH_CONV) && tick;
    assign done      = (phase == PH_DONE);
    assign err       = err_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter longint SYS_PERIOD_PS  = 200000,
    parameter longint SLOW_PERIOD_PS = 30517578,
    parameter longint TCONV_MIN_PS   = 750000,
    parameter longint TCONV_MAX_PS   = 100000000,
    parameter int     STEP_CYCLES    = 18,
    parameter int     TAIL_CYCLES    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slow_clk,
    input  logic       start,
    input  logic [2:0] clk_sel,
    input  logic [1:0] hold_sel,
    input  logic [2:0] chan,
    output logic       clk_sel_bad,
    output logic       busy,
    output logic [2:0] ch_sel,
    output logic       sample_en,
    output logic       step,
    output logic       done,
    output logic       err
);
    conv_cfg_t cfg_in;
    conv_cfg_t cfg_q;
    logic      accept;
    logic      run;
    logic      tick;

    assign cfg_in = '{ck: clk_sel, sh: hold_sel, ch: chan};

    adc_range_check #(
        .SYS_PERIOD_PS (SYS_PERIOD_PS),
        .SLOW_PERIOD_PS(SLOW_PERIOD_PS),
        .TCONV_MIN_PS  (TCONV_MIN_PS),
        .TCONV_MAX_PS  (TCONV_MAX_PS)
    ) u_range (
        .code(clk_sel),
        .bad (clk_sel_bad)
    );

    adc_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .slow_clk(slow_clk),
        .restart (accept),
        .run     (run),
        .use_slow(cfg_q.ck == CLK_SLOW),
        .ratio   (ratio_of(cfg_q.ck)),
        .tick    (tick)
    );

    adc_phase_fsm #(
        .STEP_CYCLES(STEP_CYCLES),
        .TAIL_CYCLES(TAIL_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg_in   (cfg_in),
        .tick     (tick),
        .cfg_q    (cfg_q),
        .accept   (accept),
        .run      (run),
        .busy     (busy),
        .sample_en(sample_en),
        .step     (step),
        .done     (done),
        .err      (err)
    );

    assign ch_sel = cfg_q.ch;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [1:0] hold_sel,
    input logic       busy,
    input logic [2:0] ch_sel,
    input logic       sample_en,
    input logic       step,
    input logic       done,
    input logic       err
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy && !done && !err && !sample_en && ch_sel == 3'd0)); // R1

    AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy); // R3

    AST_SAMPLE_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sample_en && step)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R5

    AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(step, 3)); // R5

    AST_CH_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ch_sel)); // R6

    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy); // R8

    AST_BAD_HOLD_ERR: assert property (@(posedge clk) disable iff (rst)
        (start && hold_sel == 2'b11 && !busy) |=> err); // R8

endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .hold_sel (hold_sel),
    .busy     (busy),
    .ch_sel   (ch_sel),
    .sample_en(sample_en),
    .step     (step),
    .done     (done),
    .err      (err)
);

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;

    typedef struct packed {
        logic [2:0] ck;
        logic [1:0] sh;
        logic [2:0] ch;
        logic [15:0] ratio;
        logic [15:0] hold;
    } vec_t;

    // Expected timing per vector: total = (18+hold)*ratio+3, sampling = hold*ratio.
    localparam vec_t VECS [0:6] = '{
        '{ck: 3'd2, sh: 2'd0, ch: 3'd3, ratio: 16'd4,  hold: 16'd2},
        '{ck: 3'd1, sh: 2'd1, ch: 3'd5, ratio: 16'd3,  hold: 16'd6},
        '{ck: 3'd0, sh: 2'd2, ch: 3'd0, ratio: 16'd2,  hold: 16'd18},
        '{ck: 3'd3, sh: 2'd0, ch: 3'd7, ratio: 16'd6,  hold: 16'd2},
        '{ck: 3'd4, sh: 2'd1, ch: 3'd1, ratio: 16'd8,  hold: 16'd6},
        '{ck: 3'd5, sh: 2'd0, ch: 3'd2, ratio: 16'd12, hold: 16'd2},
        '{ck: 3'd6, sh: 2'd2, ch: 3'd6, ratio: 16'd16, hold: 16'd18}
    };

    logic       clk = 1'b0;
    logic       slow_clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] clk_sel = 3'd2;
    logic [1:0] hold_sel = 2'd0;
    logic [2:0] chan = 3'd0;
    logic       clk_sel_bad, busy, sample_en, step, done, err;
    logic [2:0] ch_sel;
    logic       b_bad, b_busy, b_samp, b_step, b_done, b_err;
    logic [2:0] b_ch;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Measurements of one conversion.
    int r_total, r_sample, r_steps, r_first, r_last, r_gap_bad, r_ch_bad, r_busy_gap, r_done_next;

    always #4 clk = ~clk;        // 125 MHz
    always #40 slow_clk = ~slow_clk; // ten system clocks per slow period

    adc_conv_seq #(
        .SYS_PERIOD_PS (200000),
        .SLOW_PERIOD_PS(30517578)
    ) uut (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .start(start),
        .clk_sel(clk_sel), .hold_sel(hold_sel), .chan(chan),
        .clk_sel_bad(clk_sel_bad), .busy(busy), .ch_sel(ch_sel),
        .sample_en(sample_en), .step(step), .done(done), .err(err)
    );

    adc_conv_seq #(
        .SYS_PERIOD_PS (200000),
        .SLOW_PERIOD_PS(150000000)
    ) uut_slow_out (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .start(1'b0),
        .clk_sel(clk_sel), .hold_sel(hold_sel), .chan(chan),
        .clk_sel_bad(b_bad), .busy(b_busy), .ch_sel(b_ch),
        .sample_en(b_samp), .step(b_step), .done(b_done), .err(b_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_conv(input logic [2:0] ck, input logic [1:0] sh,
                            input logic [2:0] ch, input bit disturb, input int gap);
        int n;
        int prev;
        @(negedge clk);
        clk_sel = ck; hold_sel = sh; chan = ch; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1; prev = 0;
        r_sample = 0; r_steps = 0; r_first = 0; r_last = 0;
        r_gap_bad = 0; r_ch_bad = 0; r_busy_gap = 0;
        while (!done && n < 5000) begin
            if (sample_en) r_sample++;
            if (step) begin
                r_steps++;
                if (r_first == 0) r_first = n;
                if (prev != 0 && (n - prev) != gap) r_gap_bad++;
                prev = n;
                r_last = n;
            end
            if (ch_sel != ch) r_ch_bad++;
            if (!busy) r_busy_gap++;
            if (disturb && n == 5) begin chan = ~ch; clk_sel = 3'd6; hold_sel = 2'd2; start = 1'b1; end
            if (disturb && n == 6) start = 1'b0;
            @(negedge clk);
            n++;
        end
        r_total = n;
        check(!busy, "R5 busy low in done cycle", int'(busy), 0);
        @(negedge clk);
        r_done_next = int'(done);
        chan = ch;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !sample_en && !step && !err, "R1 outputs idle after reset",
              int'({busy, done, sample_en, step, err}), 0);
        check(ch_sel == 3'd0, "R1 ch_sel cleared", int'(ch_sel), 0);
        rst = 1'b0;

        // Vector table: R2, R3, R4, R5, R6
        foreach (VECS[i]) begin
            run_conv(VECS[i].ck, VECS[i].sh, VECS[i].ch, 1'b0, int'(VECS[i].ratio));
            check(r_total == (18 + int'(VECS[i].hold)) * int'(VECS[i].ratio) + 3,
                  $sformatf("R2 total time vec %0d", i), r_total,
                  (18 + int'(VECS[i].hold)) * int'(VECS[i].ratio) + 3);
            check(r_sample == int'(VECS[i].hold) * int'(VECS[i].ratio),
                  $sformatf("R3 sample length vec %0d", i), r_sample,
                  int'(VECS[i].hold) * int'(VECS[i].ratio));
            check(r_steps == 18 && r_gap_bad == 0, $sformatf("R4 step count/spacing vec %0d", i),
                  r_steps * 100 + r_gap_bad, 1800);
            check(r_first == (int'(VECS[i].hold) + 1) * int'(VECS[i].ratio),
                  $sformatf("R4 first step vec %0d", i), r_first,
                  (int'(VECS[i].hold) + 1) * int'(VECS[i].ratio));
            check(r_total - r_last == 3 && r_done_next == 0 && r_busy_gap == 0,
                  $sformatf("R5 done placement vec %0d", i),
                  (r_total - r_last) * 100 + r_done_next * 10 + r_busy_gap, 300);
            check(r_ch_bad == 0, $sformatf("R6 channel held vec %0d", i), r_ch_bad, 0);
        end

        // R6/R7: fields change and a second start arrives mid-conversion
        run_conv(3'd2, 2'd1, 3'd4, 1'b1, 4);
        check(r_total == 24 * 4 + 3, "R7 start while busy keeps timing", r_total, 99);
        check(r_ch_bad == 0, "R6 channel ignores input change", r_ch_bad, 0);
        check(r_done_next == 0 && !busy, "R7 no second conversion", int'(busy), 0);

        // R8: bad hold code
        @(negedge clk);
        clk_sel = 3'd2; hold_sel = 2'd3; chan = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err && !busy, "R8 err pulse, no busy", int'({err, busy}), 2);
        @(negedge clk);
        check(!err, "R8 err lasts one cycle", int'(err), 0);
        begin
            int seen = 0;
            for (int k = 0; k < 120; k++) begin
                if (busy || done || sample_en) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R8 no conversion ran", seen, 0);
        end
        check(ch_sel == 3'd4, "R8 channel not latched on refused start", int'(ch_sel), 4);

        // R9: slow source
        run_conv(3'd7, 2'd0, 3'd6, 1'b0, 10);
        check(r_steps == 18 && r_gap_bad == 0, "R9 slow steps count/spacing",
              r_steps * 100 + r_gap_bad, 1800);
        check(r_total - r_last == 3, "R9 done 3 after last step", r_total - r_last, 3);
        check(r_sample >= 11 && r_sample <= 20, "R9 slow sample length", r_sample, 20);

        // R10: range flag for every code on both builds
        for (int c = 0; c < 8; c++) begin
            clk_sel = 3'(c);
            #1;
            check(clk_sel_bad == (c < 2), $sformatf("R10 flag code %0d", c),
                  int'(clk_sel_bad), int'(c < 2));
            check(b_bad == (c < 2 || c == 7), $sformatf("R10 flag slow-out code %0d", c),
                  int'(b_bad), int'(c < 2 || c == 7));
        end

        // R1: reset in mid-conversion
        @(negedge clk);
        clk_sel = 3'd4; hold_sel = 2'd1; chan = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !sample_en && !step && !done && ch_sel == 3'd0,
              "R1 reset mid-conversion", int'({busy, sample_en, step, done, ch_sel}), 0);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        check(!busy && !done, "R1 stays idle after reset", int'({busy, done}), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule